// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block merges a retriggerable watchdog counter with the chip-level reset sequencer. Any reset cause starts a one-shot delay, then a fixed tail of 18 system clocks, and only then is the chip reset released. There are three causes: power becoming good, a watchdog expiry, and a wake-up from STOP mode. The delay and the watchdog window count either a slow oscillator tick, which arrives as a clock enable, or every system clock. A static option input selects the source.

The instruction decoder drives two one-cycle strobes. The first arms the watchdog, or clears its count once it is armed. The second lets the watchdog keep counting while the core is halted. Two static option inputs select permanent watchdog operation and the count source. The block also reports the cause of the most recent reset, so that a wake-up reset can leave the port direction settings untouched.

Top module: `wdt_reset_seq`

## Requirements
- R1: While `pwr_good_i` is low, `chip_rst_o` is 1 and `rst_cause_o` is 2'b01. After `pwr_good_i` rises, `chip_rst_o` stays high for the delay count of ticks plus 18 clocks. With the system-clock source that is exactly SCLK_POR_CYC+18 clocks.
- R2: After power-up without the permanent option, the watchdog is disarmed. No reset occurs, however long the core runs.
- R3: Once armed, the watchdog expires after its window of ticks counted from the last arm strobe. The expiry raises `chip_rst_o` with `rst_cause_o` = 2'b10, then runs the full delay plus 18 clocks.
- R4: Every arm strobe after the first clears the count, so refreshing more often than the window keeps the chip out of reset.
- R5: The armed state survives watchdog and wake-up resets and is lost only when power goes bad. The count is held at zero during a reset sequence and restarts when the reset is released.
- R6: With mode code 2'b01 (HALT), the count is frozen and keeps its value unless a halt-enable strobe came after arming. Once that strobe has come, the count keeps advancing in HALT. The strobe itself does not clear the count.
- R7: A halt-enable strobe given while the watchdog is disarmed has no effect, even after a later arm.
- R8: Without the permanent option, mode code 2'b10 (STOP) freezes the count.
- R9: With the permanent option, the watchdog counts from reset release without any strobe, in RUN (2'b00) and HALT. In STOP it keeps counting with the tick source and freezes with the system-clock source.
- R10: A low level on `wake_n_i` while the mode is STOP starts a reset with `rst_cause_o` = 2'b11, followed by the delay plus 18 clocks. A low level in any other mode is ignored.
- R11: With the tick source, the delay and the window advance only on clocks where `rc_tick_i` is 1. With the system-clock source they advance on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_good_i | input | 1 | Supply good; low acts as synchronous cold reset |
| rc_tick_i | input | 1 | One-clock enable from the slow oscillator |
| wake_n_i | input | 1 | Level-sensitive STOP wake-up pin, active low |
| mode_i | input | 2 | Core mode: 00 run, 01 halt, 10 stop |
| wd_arm_i | input | 1 | Arm-and-clear strobe from the decoder |
| wd_halt_i | input | 1 | Keep-counting-in-halt strobe from the decoder |
| opt_perm_i | input | 1 | Static option: watchdog permanently enabled |
| opt_sysclk_i | input | 1 | Static option: count system clocks instead of ticks |
| chip_rst_o | output | 1 | Registered chip reset, active high |
| rst_cause_o | output | 2 | Cause of the last reset: 01 power, 10 watchdog, 11 wake |

## Verification
The bench builds the block with a tick-source window of 20 and delay of 6, a system-clock window of 50 and delay of 10, and the default 18-clock tail. These values shrink every expiry and reset sequence to a few dozen cycles, so the run can step through many resets of each cause, random refresh intervals and the mode freezes. The slow tick comes every third clock, which makes the tick-source bounds and a long tick stall easy to reach.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_HALT = 2'b01,
    MODE_STOP = 2'b10
  } cpu_mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_POWER = 2'b01,
    CAUSE_WDOG  = 2'b10,
    CAUSE_WAKE  = 2'b11
  } rst_cause_e;

  typedef enum logic [1:0] {
    SQ_DELAY,
    SQ_TAIL,
    SQ_LIVE
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic       opt_sysclk_i,
  input  logic       rc_tick_i,
  input  logic [1:0] mode_i,
  output logic       tick_o,
  output logic       in_run_o,
  output logic       in_halt_o,
  output logic       in_stop_o
);
  // count source: every system clock, or only on the slow oscillator enable
  assign tick_o    = opt_sysclk_i | rc_tick_i;
  assign in_run_o  = (mode_i == MODE_RUN);
  assign in_halt_o = (mode_i == MODE_HALT);
  assign in_stop_o = (mode_i == MODE_STOP);
endmodule

// File: rtl/wrs_wdog.sv
module wrs_wdog
  import wrs_pkg::*;
#(
  parameter int RC_WDT_CYC   = 4096,
  parameter int SCLK_WDT_CYC = 130416
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  input  logic in_rst_i,
  input  logic tick_i,
  input  logic in_run_i,
  input  logic in_halt_i,
  input  logic in_stop_i,
  input  logic arm_i,
  input  logic halt_en_i,
  input  logic opt_perm_i,
  input  logic opt_sysclk_i,
  output logic expire_o
);
  localparam int WMAX = max2(RC_WDT_CYC, SCLK_WDT_CYC);
  localparam int CW   = $clog2(WMAX + 1);

  logic          armed_q;
  logic          halt_en_q;
  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] last_cnt;
  logic          wd_on;
  logic          mode_ok;
  logic          counting;
  logic          arm_fire;

  assign last_cnt = opt_sysclk_i ? CW'(SCLK_WDT_CYC - 1) : CW'(RC_WDT_CYC - 1);
  assign wd_on    = armed_q | opt_perm_i;
  assign arm_fire = arm_i & ~in_rst_i;

  always_comb begin
    mode_ok = 1'b0;
    if (in_run_i)       mode_ok = 1'b1;
    else if (in_halt_i) mode_ok = halt_en_q | opt_perm_i;
    else if (in_stop_i) mode_ok = opt_perm_i & ~opt_sysclk_i;
  end

  assign counting = wd_on & mode_ok & ~in_rst_i & tick_i;
  assign expire_o = counting & (wcnt_q == last_cnt) & ~arm_fire;

  always_ff @(posedge clk_i) begin
    if (!pwr_good_i) begin
      armed_q   <= 1'b0;
      halt_en_q <= 1'b0;
      wcnt_q    <= '0;
    end else begin
      if (arm_fire) armed_q <= 1'b1;
      if (halt_en_i && armed_q && !in_rst_i) halt_en_q <= 1'b1;
      if (in_rst_i || arm_fire || expire_o) wcnt_q <= '0;
      else if (counting)                    wcnt_q <= wcnt_q + 1'b1;
    end
  end

  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!pwr_good_i) armed_q |=> armed_q); // R5
  AST_HALT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!pwr_good_i) halt_en_q |-> armed_q); // R7
  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!pwr_good_i) (in_stop_i && !opt_perm_i && !arm_i && !in_rst_i) |=> $stable(wcnt_q)); // R8
  AST_RST_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!pwr_good_i) in_rst_i |=> (wcnt_q == '0)); // R5
endmodule

// File: rtl/wrs_seq.sv
module wrs_seq
  import wrs_pkg::*;
#(
  parameter int RC_POR_CYC   = 512,
  parameter int SCLK_POR_CYC = 16362,
  parameter int TAIL_CYC     = 18
) (
  input  logic       clk_i,
  input  logic       pwr_good_i,
  input  logic       opt_sysclk_i,
  input  logic       tick_i,
  input  logic       expire_i,
  input  logic       in_stop_i,
  input  logic       wake_n_i,
  output logic       chip_rst_o,
  output logic [1:0] cause_o
);
  localparam int PMAX = max2(RC_POR_CYC, SCLK_POR_CYC);
  localparam int DW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TAIL_CYC + 1);

  seq_state_e    state_q;
  rst_cause_e    cause_q;
  logic          chip_rst_q;
  logic [DW-1:0] dcnt_q;
  logic [TW-1:0] tcnt_q;
  logic [DW-1:0] delay_last;
  logic          wake_req;

  assign delay_last = opt_sysclk_i ? DW'(SCLK_POR_CYC - 1) : DW'(RC_POR_CYC - 1);
  // level sensitive: the pin is sampled every clock while the core sleeps
  assign wake_req   = ~chip_rst_q & in_stop_i & ~wake_n_i;

  always_ff @(posedge clk_i) begin
    if (!pwr_good_i) begin
      state_q    <= SQ_DELAY;
      cause_q    <= CAUSE_POWER;
      chip_rst_q <= 1'b1;
      dcnt_q     <= '0;
      tcnt_q     <= '0;
    end else if (expire_i) begin
      state_q    <= SQ_DELAY;
      cause_q    <= CAUSE_WDOG;
      chip_rst_q <= 1'b1;
      dcnt_q     <= '0;
      tcnt_q     <= '0;
    end else if (wake_req) begin
      state_q    <= SQ_DELAY;
      cause_q    <= CAUSE_WAKE;
      chip_rst_q <= 1'b1;
      dcnt_q     <= '0;
      tcnt_q     <= '0;
    end else begin
      case (state_q)
        SQ_DELAY: begin
          if (tick_i) begin
            if (dcnt_q == delay_last) begin
              state_q <= SQ_TAIL;
              dcnt_q  <= '0;
              tcnt_q  <= '0;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
        end
        SQ_TAIL: begin
          if (tcnt_q == TW'(TAIL_CYC - 1)) begin
            state_q    <= SQ_LIVE;
            chip_rst_q <= 1'b0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: begin
          chip_rst_q <= 1'b0;
        end
      endcase
    end
  end

  assign chip_rst_o = chip_rst_q;
  assign cause_o    = cause_q;

  AST_EXPIRE_RESETS: assert property (@(posedge clk_i) disable iff (!pwr_good_i) expire_i |=> (chip_rst_q && cause_q == CAUSE_WDOG)); // R3
  AST_WAKE_RESETS: assert property (@(posedge clk_i) disable iff (!pwr_good_i) (wake_req && !expire_i) |=> (chip_rst_q && cause_q == CAUSE_WAKE)); // R10
  AST_TAIL_LEN: assert property (@(posedge clk_i) disable iff (!pwr_good_i) $fell(chip_rst_q) |-> ($past(state_q) == SQ_TAIL && $past(tcnt_q) == TW'(TAIL_CYC - 1))); // R1
  AST_RST_UNTIL_LIVE: assert property (@(posedge clk_i) disable iff (!pwr_good_i) (state_q != SQ_LIVE) |-> chip_rst_q); // R1
endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
  import wrs_pkg::*;
#(
  parameter int RC_WDT_CYC   = 4096,
  parameter int RC_POR_CYC   = 512,
  parameter int SCLK_WDT_CYC = 130416,
  parameter int SCLK_POR_CYC = 16362,
  parameter int TAIL_CYC     = 18
) (
  input  logic       clk_i,
  input  logic       pwr_good_i,
  input  logic       rc_tick_i,
  input  logic       wake_n_i,
  input  logic [1:0] mode_i,
  input  logic       wd_arm_i,
  input  logic       wd_halt_i,
  input  logic       opt_perm_i,
  input  logic       opt_sysclk_i,
  output logic       chip_rst_o,
  output logic [1:0] rst_cause_o
);
  logic tick;
  logic in_run;
  logic in_halt;
  logic in_stop;
  logic expire;
  logic chip_rst;

  wrs_decode u_decode (
    .opt_sysclk_i (opt_sysclk_i),
    .rc_tick_i    (rc_tick_i),
    .mode_i       (mode_i),
    .tick_o       (tick),
    .in_run_o     (in_run),
    .in_halt_o    (in_halt),
    .in_stop_o    (in_stop)
  );

  wrs_wdog #(
    .RC_WDT_CYC   (RC_WDT_CYC),
    .SCLK_WDT_CYC (SCLK_WDT_CYC)
  ) u_wdog (
    .clk_i        (clk_i),
    .pwr_good_i   (pwr_good_i),
    .in_rst_i     (chip_rst),
    .tick_i       (tick),
    .in_run_i     (in_run),
    .in_halt_i    (in_halt),
    .in_stop_i    (in_stop),
    .arm_i        (wd_arm_i),
    .halt_en_i    (wd_halt_i),
    .opt_perm_i   (opt_perm_i),
    .opt_sysclk_i (opt_sysclk_i),
    .expire_o     (expire)
  );

  wrs_seq #(
    .RC_POR_CYC   (RC_POR_CYC),
    .SCLK_POR_CYC (SCLK_POR_CYC),
    .TAIL_CYC     (TAIL_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .pwr_good_i   (pwr_good_i),
    .opt_sysclk_i (opt_sysclk_i),
    .tick_i       (tick),
    .expire_i     (expire),
    .in_stop_i    (in_stop),
    .wake_n_i     (wake_n_i),
    .chip_rst_o   (chip_rst),
    .cause_o      (rst_cause_o)
  );

  assign chip_rst_o = chip_rst;
endmodule

// File: tb/wdt_reset_seq_bench.sv
module wdt_reset_seq_bench;
  localparam int RC_TO  = 20;
  localparam int RC_POR = 6;
  localparam int SC_TO  = 50;
  localparam int SC_POR = 10;
  localparam int TAIL   = 18;
  localparam int TP     = 3;
  localparam int LIM    = 20000;
  localparam int WD_CYC = 100000;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       wake_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       arm = 1'b0;
  logic       halt_en = 1'b0;
  logic       perm = 1'b0;
  logic       sysclk = 1'b1;
  logic       tick_en = 1'b0;
  logic       rc_tick;
  logic       chip_rst;
  logic [1:0] cause;
  int         tk_ph = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  always @(negedge clk) tk_ph <= (tk_ph == TP - 1) ? 0 : tk_ph + 1;
  assign rc_tick = tick_en && (tk_ph == 0);

  wdt_reset_seq #(
    .RC_WDT_CYC(RC_TO), .RC_POR_CYC(RC_POR),
    .SCLK_WDT_CYC(SC_TO), .SCLK_POR_CYC(SC_POR), .TAIL_CYC(TAIL)
  ) u_wdt_reset_seq (
    .clk_i(clk), .pwr_good_i(pwr_good), .rc_tick_i(rc_tick), .wake_n_i(wake_n),
    .mode_i(mode), .wd_arm_i(arm), .wd_halt_i(halt_en), .opt_perm_i(perm),
    .opt_sysclk_i(sysclk), .chip_rst_o(chip_rst), .rst_cause_o(cause)
  );

  function automatic int exp_release_sc();
    return SC_POR + TAIL;
  endfunction
  function automatic int exp_rise_sc(input int used);
    return SC_TO - used;
  endfunction
  function automatic int rc_lo(input int n);
    return (n - 1) * TP + 1;
  endfunction
  function automatic int rc_hi(input int n);
    return n * TP;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release(output int e);
    e = 0;
    while (chip_rst === 1'b1 && e < LIM) begin
      @(negedge clk);
      e++;
    end
  endtask

  task automatic wait_rise(input int lim, output int e);
    e = 0;
    while (chip_rst === 1'b0 && e < lim) begin
      @(negedge clk);
      e++;
    end
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic power_up(input bit p, input bit s, input bit t, output int e);
    pwr_good = 1'b0;
    perm = p;
    sysclk = s;
    tick_en = t;
    mode = 2'b00;
    wake_n = 1'b1;
    arm = 1'b0;
    halt_en = 1'b0;
    step(3);
    check(chip_rst === 1'b1, "R1 reset held while power bad", chip_rst, 1);
    check(cause === 2'b01, "R1 power cause", cause, 1);
    pwr_good = 1'b1;
    wait_release(e);
  endtask

  initial begin
    @(posedge clk);
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc >= WD_CYC) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_CYC);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int e;
    int k;
    int sd;
    sd = $urandom(32'd4242);
    @(negedge clk);

    // R1 power-up, system-clock source
    power_up(1'b0, 1'b1, 1'b0, e);
    check(e == exp_release_sc(), "R1 power-up release length", e, exp_release_sc());
    check(cause === 2'b01, "R1 cause after release", cause, 1);

    // R2 disarmed watchdog never fires
    wait_rise(3 * SC_TO, e);
    check(chip_rst === 1'b0, "R2 no reset while disarmed", chip_rst, 0);

    // R7 halt-enable before arming is ignored; R6 halt freezes count
    halt_en = 1'b1;
    @(negedge clk);
    halt_en = 1'b0;
    pulse_arm();
    k = 10;
    step(k);
    mode = 2'b01;
    step(100);
    check(chip_rst === 1'b0, "R7 halt frozen after early halt-enable", chip_rst, 0);
    mode = 2'b00;
    wait_rise(LIM, e);
    check(e == exp_rise_sc(k), "R6 count kept across halt", e, exp_rise_sc(k));
    check(cause === 2'b10, "R3 watchdog cause", cause, 2);
    wait_release(e);
    check(e == exp_release_sc(), "R3 watchdog reset length", e, exp_release_sc());

    // R5 armed state survives the watchdog reset
    wait_rise(LIM, e);
    check(e == SC_TO, "R5 rearmed after watchdog reset", e, SC_TO);
    wait_release(e);

    // R4 random refresh intervals keep chip alive
    for (int i = 0; i < 25; i++) begin
      pulse_arm();
      k = $urandom_range(1, SC_TO - 2);
      step(k);
      check(chip_rst === 1'b0, "R4 refresh keeps chip alive", chip_rst, 0);
    end
    pulse_arm();
    k = $urandom_range(1, SC_TO - 2);
    step(k);
    wait_rise(LIM, e);
    check(e == exp_rise_sc(k), "R4 expiry measured from last refresh", e, exp_rise_sc(k));
    wait_release(e);

    // R6 halt-enable after arming keeps counting, does not clear
    pulse_arm();
    k = 12;
    step(k);
    halt_en = 1'b1;
    @(negedge clk);
    halt_en = 1'b0;
    mode = 2'b01;
    wait_rise(LIM, e);
    check(e == exp_rise_sc(k + 1), "R6 counting in halt", e, exp_rise_sc(k + 1));
    mode = 2'b00;
    wait_release(e);

    // R8 stop freezes count without permanent option
    pulse_arm();
    k = 7;
    step(k);
    mode = 2'b10;
    step(200);
    check(chip_rst === 1'b0, "R8 stop frozen", chip_rst, 0);
    mode = 2'b00;
    wait_rise(LIM, e);
    check(e == exp_rise_sc(k), "R8 count kept across stop", e, exp_rise_sc(k));
    wait_release(e);

    // R10 wake pin outside STOP ignored, then wake-up reset
    pulse_arm();
    wake_n = 1'b0;
    step(10);
    check(chip_rst === 1'b0, "R10 wake pin ignored in run", chip_rst, 0);
    wake_n = 1'b1;
    pulse_arm();
    mode = 2'b10;
    wake_n = 1'b0;
    @(negedge clk);
    check(chip_rst === 1'b1, "R10 wake starts reset", chip_rst, 1);
    check(cause === 2'b11, "R10 wake cause", cause, 3);
    mode = 2'b00;
    wake_n = 1'b1;
    wait_release(e);
    check(e == exp_release_sc(), "R10 wake reset length", e, exp_release_sc());
    wait_rise(LIM, e);
    check(e == SC_TO, "R5 armed survives wake reset", e, SC_TO);
    wait_release(e);

    // R9 permanent option, system-clock source
    power_up(1'b1, 1'b1, 1'b0, e);
    check(e == exp_release_sc(), "R1 release length with permanent option", e, exp_release_sc());
    step(10);
    mode = 2'b01;
    step(15);
    mode = 2'b10;
    step(100);
    check(chip_rst === 1'b0, "R9 system-clock source frozen in stop", chip_rst, 0);
    mode = 2'b00;
    wait_rise(LIM, e);
    check(e == SC_TO - 25, "R9 permanent counts in run and halt", e, SC_TO - 25);
    wait_release(e);

    // R9 / R11 permanent option, tick source keeps counting in stop
    power_up(1'b1, 1'b0, 1'b1, e);
    check(e >= rc_lo(RC_POR) + TAIL && e <= rc_hi(RC_POR) + TAIL, "R11 tick-source delay", e, rc_hi(RC_POR) + TAIL);
    mode = 2'b10;
    wait_rise(LIM, e);
    check(e >= rc_lo(RC_TO) && e <= rc_hi(RC_TO), "R9 tick-source counts in stop", e, rc_hi(RC_TO));
    check(cause === 2'b10, "R9 watchdog cause in stop", cause, 2);
    mode = 2'b00;
    wait_release(e);

    // R11 no ticks means no progress
    power_up(1'b0, 1'b0, 1'b1, e);
    check(e >= rc_lo(RC_POR) + TAIL && e <= rc_hi(RC_POR) + TAIL, "R11 delay counts ticks", e, rc_hi(RC_POR) + TAIL);
    pulse_arm();
    tick_en = 1'b0;
    step(500);
    check(chip_rst === 1'b0, "R11 stalled tick holds count", chip_rst, 0);
    tick_en = 1'b1;
    wait_rise(LIM, e);
    check(e >= rc_lo(RC_TO) && e <= rc_hi(RC_TO), "R11 expiry after ticks resume", e, rc_hi(RC_TO));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule